// File: doc/BRIEF.md
# Periodic Register-Write Playback Sequencer

This block plays a stored sample sequence back as a series of internal register-write commands. A step is taken once every programmed number of frame periods. For each step the block reads one sample from an external synchronous memory. It then issues a write command that carries the sample, a configured card address, a configured parameter ID and a configured count of data words per command. The command leaves through a valid/ready handshake. The sequencer stalls for as long as the receiver is not ready.

A 2-bit mode input gates playback. Only the waveform-playback code starts steps. The disabled, housekeeping and ramp codes leave the sequencer idle, because the generators for those modes live elsewhere. On entry to playback, stepping starts at the index currently held in the host's memory address register. Each later step moves to the next index, and the index wraps to zero after the last sample of the programmed length. The value of the last accepted command is held on a report output, so that the packet builder can place it in header word 7 of the next data packet.

Top module: `wave_playback_seq`

## Requirements
- R1: After reset, `cmd_valid_o` and `mem_rd_o` are low and `hdr_value_o` is 0.
- R2: Commands are produced only while `mode_i` is 2'b11 (playback). Codes 2'b00 (disabled), 2'b01 (housekeeping) and 2'b10 (ramp) produce no memory reads and no commands.
- R3: The first command after playback is entered carries the sample at the index on `start_idx_i`, sampled in the cycle of entry. Entry is the first cycle in which mode is 2'b11 and the length is non-zero.
- R4: After the command for index i is accepted, the next index is 0 if i+1 >= `seq_len_i`, and i+1 otherwise.
- R5: Counting `frame_tick_i` pulses from entry, a step becomes due on every N-th pulse, where N is `step_period_i`. A period of 0 behaves as 1.
- R6: Each command carries `card_addr_i`, `param_id_i` and `data_num_i` as they were in the cycle the sample was captured.
- R7: When `seq_len_i` is 0, no reads and no commands are produced in any mode.
- R8: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command stays valid with an unchanged payload, and no new read starts.
- R9: When the mode leaves 2'b11, a read already started still completes and is delivered. No further step starts. Re-entering playback restarts from `start_idx_i`.
- R10: `hdr_value_o` takes the data of each accepted command on the edge that accepts it, and changes at no other time.
- R11: A read is a single-cycle pulse on `mem_rd_o` with `mem_addr_o` valid. The data is expected on `mem_data_i` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Internal command mode |
| seq_len_i | input | IDX_W+1 | Number of samples in the sequence |
| start_idx_i | input | IDX_W | Host memory address register, used as the start index |
| step_period_i | input | PER_W | Frame periods per step |
| card_addr_i | input | CARD_W | Target card address |
| param_id_i | input | PARAM_W | Target parameter ID |
| data_num_i | input | NUM_W | Data words per command |
| frame_tick_i | input | 1 | One-cycle pulse at the end of each data packet |
| mem_rd_o | output | 1 | Sample memory read strobe |
| mem_addr_o | output | IDX_W | Sample memory read index |
| mem_data_i | input | DATA_W | Sample memory read data, one cycle after the strobe |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command ready |
| cmd_card_o | output | CARD_W | Command card address |
| cmd_param_o | output | PARAM_W | Command parameter ID |
| cmd_num_o | output | NUM_W | Command data-word count |
| cmd_data_o | output | DATA_W | Command sample value |
| hdr_value_o | output | DATA_W | Last applied value, for header word 7 |

## Verification
The bench builds the block with an 8-entry index space (IDX_W=3) and a 2-bit step period. This makes every mode code, every period from 0 to 3, lengths 0, 1, 3 and 8, and start indexes both inside and beyond the length reachable in one sweep. Each case runs enough frames to wrap the full 8-entry sequence. The expected index sequence and step frames are computed arithmetically from the requirements. Separate cases hold ready low across frame pulses, and drop the mode while a command is waiting.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_CAPT  = 2'd2,
    ST_SEND  = 2'd3
  } wps_state_e;

  localparam logic [1:0] MODE_PLAYBACK = 2'b11;
endpackage

// File: rtl/wps_frame_div.sv
module wps_frame_div #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             take_i,
  input  logic [PER_W-1:0] period_i,
  output logic             due_o
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W:0]   per_eff, cnt_inc;

  assign per_eff = (period_i == '0) ? (PER_W+1)'(1) : {1'b0, period_i};
  assign cnt_inc = {1'b0, cnt_q} + (PER_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      due_o <= 1'b0;
    end else if (!run_i || clear_i) begin
      cnt_q <= '0;
      due_o <= 1'b0;
    end else begin
      if (take_i) due_o <= 1'b0;
      if (tick_i) begin
        // >= guards against the period shrinking mid-count
        if (cnt_inc >= per_eff) begin
          cnt_q <= '0;
          due_o <= 1'b1;
        end else begin
          cnt_q <= cnt_inc[PER_W-1:0];
        end
      end
    end
  end

  p_due_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(due_o) |-> $past(tick_i));

  p_idle_no_due_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !due_o);
endmodule

// File: rtl/wps_index.sv
module wps_index #(
  parameter int IDX_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] start_i,
  input  logic             adv_i,
  input  logic [IDX_W:0]   len_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W:0] idx_inc;
  logic           at_end;

  assign idx_inc = {1'b0, idx_o} + (IDX_W+1)'(1);
  assign at_end  = (idx_inc >= len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (load_i) idx_o <= start_i;
    else if (adv_i)  idx_o <= at_end ? '0 : idx_inc[IDX_W-1:0];
  end

  p_load_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> idx_o == $past(start_i));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && at_end) |=> idx_o == '0);
endmodule

// File: rtl/wave_playback_seq.sv
module wave_playback_seq
  import wps_pkg::*;
#(
  parameter int IDX_W   = 13,
  parameter int DATA_W  = 32,
  parameter int PER_W   = 16,
  parameter int CARD_W  = 4,
  parameter int PARAM_W = 8,
  parameter int NUM_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [IDX_W:0]     seq_len_i,
  input  logic [IDX_W-1:0]   start_idx_i,
  input  logic [PER_W-1:0]   step_period_i,
  input  logic [CARD_W-1:0]  card_addr_i,
  input  logic [PARAM_W-1:0] param_id_i,
  input  logic [NUM_W-1:0]   data_num_i,
  input  logic               frame_tick_i,
  output logic               mem_rd_o,
  output logic [IDX_W-1:0]   mem_addr_o,
  input  logic [DATA_W-1:0]  mem_data_i,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic [CARD_W-1:0]  cmd_card_o,
  output logic [PARAM_W-1:0] cmd_param_o,
  output logic [NUM_W-1:0]   cmd_num_o,
  output logic [DATA_W-1:0]  cmd_data_o,
  output logic [DATA_W-1:0]  hdr_value_o
);
  wps_state_e     state_q;
  logic           active, active_q, entry;
  logic           due, take, accept, adv;
  logic [IDX_W-1:0] idx;

  assign active = (mode_i == MODE_PLAYBACK) && (seq_len_i != '0);
  assign entry  = active && !active_q;
  assign take   = (state_q == ST_IDLE) && active && due;
  assign accept = (state_q == ST_SEND) && cmd_ready_i;
  // index frozen once playback is left
  assign adv    = accept && active && !entry;

  assign mem_rd_o    = (state_q == ST_FETCH);
  assign mem_addr_o  = idx;
  assign cmd_valid_o = (state_q == ST_SEND);

  wps_frame_div #(.PER_W(PER_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (active),
    .clear_i  (entry),
    .tick_i   (frame_tick_i),
    .take_i   (take),
    .period_i (step_period_i),
    .due_o    (due)
  );

  wps_index #(.IDX_W(IDX_W)) u_idx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (entry),
    .start_i (start_idx_i),
    .adv_i   (adv),
    .len_i   (seq_len_i),
    .idx_o   (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cmd_card_o  <= '0;
      cmd_param_o <= '0;
      cmd_num_o   <= '0;
      cmd_data_o  <= '0;
      hdr_value_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (take) state_q <= ST_FETCH;
        ST_FETCH: state_q <= ST_CAPT;
        ST_CAPT: begin
          cmd_data_o  <= mem_data_i;
          cmd_card_o  <= card_addr_i;
          cmd_param_o <= param_id_i;
          cmd_num_o   <= data_num_i;
          state_q     <= ST_SEND;
        end
        ST_SEND: if (cmd_ready_i) begin
          hdr_value_o <= cmd_data_o;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o && $stable(cmd_data_o)
      && $stable(cmd_card_o) && $stable(cmd_param_o) && $stable(cmd_num_o));

  p_no_rd_while_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !mem_rd_o);

  p_rd_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  p_rd_needs_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_rd_o) |-> ($past(mode_i) == MODE_PLAYBACK) && ($past(seq_len_i) != '0));

  p_hdr_on_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hdr_value_o) |-> $past(cmd_valid_o && cmd_ready_i));
endmodule

// File: tb/wave_playback_seq_tb.sv
module wave_playback_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 3, DATA_W = 8, PER_W = 2, CARD_W = 4, PARAM_W = 8, NUM_W = 4;
  localparam int FRAME_GAP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [IDX_W:0] seq_len = '0;
  logic [IDX_W-1:0] start_idx = '0;
  logic [PER_W-1:0] step_period = '0;
  logic [CARD_W-1:0] card = 4'h5;
  logic [PARAM_W-1:0] param = 8'h99;
  logic [NUM_W-1:0] dnum = 4'h1;
  logic tick = 1'b0, ready = 1'b1;
  logic mem_rd, cmd_valid;
  logic [IDX_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data = '0, cmd_data, hdr_value;
  logic [CARD_W-1:0] cmd_card;
  logic [PARAM_W-1:0] cmd_param;
  logic [NUM_W-1:0] cmd_num;

  int checks = 0, errors = 0, hs_cnt = 0;
  logic [DATA_W-1:0] hs_data = '0;
  logic [CARD_W-1:0] hs_card = '0;
  logic [PARAM_W-1:0] hs_param = '0;
  logic [NUM_W-1:0] hs_num = '0;
  int rd_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_playback_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W), .PER_W(PER_W),
    .CARD_W(CARD_W), .PARAM_W(PARAM_W), .NUM_W(NUM_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .seq_len_i(seq_len),
    .start_idx_i(start_idx), .step_period_i(step_period), .card_addr_i(card),
    .param_id_i(param), .data_num_i(dnum), .frame_tick_i(tick),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(ready), .cmd_card_o(cmd_card),
    .cmd_param_o(cmd_param), .cmd_num_o(cmd_num), .cmd_data_o(cmd_data),
    .hdr_value_o(hdr_value));

  function automatic logic [DATA_W-1:0] mem_val(int a);
    return DATA_W'(8'h30 + a * 7);
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= mem_val(int'(mem_addr));

  always @(negedge clk) begin
    if (rst_n && mem_rd) rd_cnt++;
    if (rst_n && cmd_valid && ready) begin
      hs_cnt++;
      hs_data = cmd_data; hs_card = cmd_card; hs_param = cmd_param; hs_num = cmd_num;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    cycles(FRAME_GAP);
  endtask

  task automatic run_case(int m, int len, int per, int st, int frames);
    int neff, idx_e, h0, r0;
    logic [DATA_W-1:0] exp_d;
    neff = (per == 0) ? 1 : per;
    idx_e = st;
    seq_len = (IDX_W+1)'(len); step_period = PER_W'(per); start_idx = IDX_W'(st);
    card = CARD_W'(m + per); param = PARAM_W'(8'h40 + len); dnum = NUM_W'(st + 1);
    r0 = rd_cnt;
    @(negedge clk); mode = 2'(m);
    cycles(2);
    for (int f = 1; f <= frames; f++) begin
      h0 = hs_cnt;
      frame();
      if (m == 3 && len != 0 && (f % neff) == 0) begin
        exp_d = mem_val(idx_e);
        check("R5 step count", hs_cnt - h0, 1);
        check(idx_e == st && f == neff ? "R3 first sample" : "R4 sample order", int'(hs_data), int'(exp_d));
        check("R6 card", int'(hs_card), m + per);
        check("R6 param", int'(hs_param), 8'h40 + len);
        check("R6 num", int'(hs_num), st + 1);
        check("R10 header value", int'(hdr_value), int'(exp_d));
        idx_e = (idx_e + 1 >= len) ? 0 : idx_e + 1;
      end else begin
        check(len == 0 ? "R7 no command" : (m != 3 ? "R2 no command" : "R5 no step"), hs_cnt - h0, 0);
      end
    end
    if (m != 3 || len == 0)
      check(len == 0 ? "R7 no read" : "R2 no read", rd_cnt - r0, 0);
    @(negedge clk); mode = 2'd0;
    cycles(3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int h0, r0;
    cycles(3);
    check("R1 valid at reset", int'(cmd_valid), 0);
    check("R1 read at reset", int'(mem_rd), 0);
    check("R1 header at reset", int'(hdr_value), 0);
    rst_n = 1'b1;
    cycles(2);

    // near-exhaustive sweep
    for (int m = 0; m < 4; m++)
      for (int per = 0; per < 4; per++)
        for (int li = 0; li < 4; li++)
          for (int st = 0; st < 3; st += 2) begin
            int len;
            len = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 3 : 8;
            run_case(m, len, per, st, (m == 3) ? 9 * ((per == 0) ? 1 : per) : 4);
          end

    // R8: stall with ready low across frames
    seq_len = 4'd4; step_period = 2'd1; start_idx = 3'd1; ready = 1'b0;
    @(negedge clk); mode = 2'd3; cycles(2);
    h0 = hs_cnt; r0 = rd_cnt;
    frame();
    check("R8 valid while stalled", int'(cmd_valid), 1);
    check("R8 payload while stalled", int'(cmd_data), int'(mem_val(1)));
    frame();
    check("R8 held payload", int'(cmd_data), int'(mem_val(1)));
    check("R8 no second read", rd_cnt - r0, 1);
    check("R11 single read pulse", rd_cnt - r0, 1);
    @(negedge clk); ready = 1'b1;
    cycles(8);
    check("R8 both delivered", hs_cnt - h0, 2);
    check("R8 second sample", int'(hs_data), int'(mem_val(2)));
    check("R10 header after stall", int'(hdr_value), int'(mem_val(2)));

    // R9: leave mode with a command waiting
    @(negedge clk); mode = 2'd0; cycles(3);
    start_idx = 3'd0; ready = 1'b0;
    @(negedge clk); mode = 2'd3; cycles(2);
    h0 = hs_cnt;
    frame();
    check("R9 waiting command", int'(cmd_valid), 1);
    @(negedge clk); mode = 2'd0; cycles(3);
    ready = 1'b1; cycles(3);
    check("R9 pending completes", hs_cnt - h0, 1);
    check("R9 pending data", int'(hs_data), int'(mem_val(0)));
    h0 = hs_cnt;
    frame(); frame();
    check("R9 no step after leave", hs_cnt - h0, 0);
    start_idx = 3'd6;
    @(negedge clk); mode = 2'd3; cycles(2);
    frame();
    check("R9 restart count", hs_cnt - h0, 1);
    check("R9 restart from start", int'(hs_data), int'(mem_val(6)));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule